// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps CPU-side addresses that land inside a fixed outbound region onto a wider bus address space. The region is divided into a row of equally sized windows. A 3-bit index sets the window size to a power-of-two number of megabytes. Each window holds its own 64-bit replacement base and its own valid flag. A single global enable bit gates every translation.

Software programs the block through a 32-bit register port. There is one control word, one size word, and a low and a high word for each window. The low word holds the window's valid flag in bit 0 and the upper part of its replacement base.

A request carries an address and a valid flag. One cycle later the block returns a 64-bit address with either a hit or a miss. On a hit the window's base is substituted for the address bits above the window size. On a miss the 32-bit address is passed through, zero-extended.

Top module: `ob_xlate`

## Requirements
- R1: After reset every register reads zero. A translation request then reports a miss and returns its own address zero-extended.
- R2: The control word at 0x004 reads back the full 32 bits last written. For window n, the low word is at 0x200+8n and the high word is at 0x204+8n, and each reads back the full 32 bits last written.
- R3: The size word at 0x030 keeps only bits 2:0 of a write and reads zero in bits 31:3.
- R4: Any other offset reads zero, and a write to it changes no register. This covers offset 0x000, byte offsets that are not word-aligned, and offsets at or past 0x200+8·NUM_WIN.
- R5: The window size is 2^(20+k) bytes, where k is the size index. The window number of an address is (address − REGION_BASE) shifted right by 20+k.
- R6: A hit returns {high word, low word with its low 20+k bits cleared} plus the address's offset inside its window. It asserts hit and deasserts miss.
- R7: While bit 1 of the control word is clear, every request misses and returns its own address zero-extended, whatever the windows hold.
- R8: A request that falls in a window whose low word has bit 0 clear misses and returns its own address.
- R9: An address below REGION_BASE, or one whose window number is NUM_WIN or larger, misses and returns its own address.
- R10: A result appears on the clock edge after the request, with out_vld_o set and exactly one of hit and miss set. In a cycle after no request, out_vld_o, hit and miss are all low. Back-to-back requests each get their own result.
- R11: A register write takes effect for requests made in the following cycle. A request made in the same cycle as the write is translated with the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| xl_vld_i | input | 1 | Translation request valid |
| xl_addr_i | input | 32 | CPU-side address to translate |
| out_vld_o | output | 1 | Translation result valid |
| out_addr_o | output | 64 | Translated or passed-through address |
| out_hit_o | output | 1 | Address was translated through a window |
| out_miss_o | output | 1 | Address was passed through unchanged |

## Verification
The hardest case to reach is one where the size index, the window number and the offset inside the window all interact. This happens when the same address changes windows as the size changes, and when the last window or the first index past the array is hit. The stimulus reprograms the size to 1 MB, 8 MB and 128 MB against one fixed set of window bases. It aims at addresses one byte before the region, at the last byte of window 31, and at the first byte past it. A separate scenario issues a request in the same cycle as a write that invalidates the target window. This shows the old contents are used for that request and the new contents for the next one.

// File: rtl/ob_xlate_pkg.sv
`timescale 1ns/1ps
package ob_xlate_pkg;

    localparam int unsigned DATA_W        = 32;
    localparam int unsigned REG_AW        = 12;
    localparam int unsigned MB_SHIFT      = 20;
    localparam int unsigned SZ_IDX_W      = 3;
    localparam int unsigned CTRL_EN_BIT   = 1;
    localparam int unsigned WIN_VLD_BIT   = 0;

    localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h004;
    localparam logic [REG_AW-1:0] OFS_SIZE     = 12'h030;
    localparam int unsigned       OFS_WIN_BASE = 32'h200;
    localparam int unsigned       WIN_STRIDE   = 8;
    localparam int unsigned       HI_WORD_OFS  = 4;

    // one window: replacement base (high and low words)
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } win_entry_t;

    // result of one lookup
    typedef struct packed {
        logic              hit;
        logic [2*DATA_W-1:0] addr;
    } xl_result_t;

    // bit position of the first address bit above the window offset
    function automatic logic [4:0] win_shift(input logic [SZ_IDX_W-1:0] k);
        return 5'(MB_SHIFT) + {2'b00, k};
    endfunction

    // mask of the offset-inside-window bits
    function automatic logic [DATA_W-1:0] win_mask(input logic [SZ_IDX_W-1:0] k);
        return (DATA_W'(1) << win_shift(k)) - DATA_W'(1);
    endfunction

endpackage

// File: rtl/ob_xlate_regs.sv
`timescale 1ns/1ps
module ob_xlate_regs
    import ob_xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                xl_en_o,
    output logic [SZ_IDX_W-1:0] size_idx_o,
    output win_entry_t [NUM_WIN-1:0] win_o
);

    logic [DATA_W-1:0]   ctrl_q;
    logic [SZ_IDX_W-1:0] size_q;
    logic                ctrl_sel;
    logic                size_sel;
    logic [NUM_WIN-1:0]  lo_sel;
    logic [NUM_WIN-1:0]  hi_sel;

    assign ctrl_sel = (addr_i == OFS_CTRL);
    assign size_sel = (addr_i == OFS_SIZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            size_q <= '0;
        end else if (we_i) begin
            if (ctrl_sel) ctrl_q <= wdata_i;
            if (size_sel) size_q <= wdata_i[SZ_IDX_W-1:0];
        end
    end

    // per-window storage and address match
    for (genvar gw = 0; gw < NUM_WIN; gw++) begin : g_win
        localparam logic [REG_AW-1:0] LO_OFS = REG_AW'(OFS_WIN_BASE + WIN_STRIDE * gw);
        localparam logic [REG_AW-1:0] HI_OFS = REG_AW'(OFS_WIN_BASE + WIN_STRIDE * gw + HI_WORD_OFS);

        logic [DATA_W-1:0] lo_q;
        logic [DATA_W-1:0] hi_q;

        assign lo_sel[gw] = (addr_i == LO_OFS);
        assign hi_sel[gw] = (addr_i == HI_OFS);

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (we_i) begin
                if (lo_sel[gw]) lo_q <= wdata_i;
                if (hi_sel[gw]) hi_q <= wdata_i;
            end
        end

        assign win_o[gw].lo = lo_q;
        assign win_o[gw].hi = hi_q;
    end

    always_comb begin
        rdata_o = '0;
        if (ctrl_sel) rdata_o = ctrl_q;
        if (size_sel) rdata_o = {{(DATA_W-SZ_IDX_W){1'b0}}, size_q};
        for (int n = 0; n < NUM_WIN; n++) begin
            if (lo_sel[n]) rdata_o = win_o[n].lo;
            if (hi_sel[n]) rdata_o = win_o[n].hi;
        end
    end

    assign xl_en_o    = ctrl_q[CTRL_EN_BIT];
    assign size_idx_o = size_q;

endmodule

// File: rtl/ob_xlate_lookup.sv
`timescale 1ns/1ps
module ob_xlate_lookup
    import ob_xlate_pkg::*;
#(
    parameter int unsigned       NUM_WIN     = 32,
    parameter logic [DATA_W-1:0] REGION_BASE = 32'h4000_0000
) (
    input  logic                     xl_en_i,
    input  logic [SZ_IDX_W-1:0]      size_idx_i,
    input  win_entry_t [NUM_WIN-1:0] win_i,
    input  logic [DATA_W-1:0]        addr_i,
    output xl_result_t               res_o
);

    logic [DATA_W-1:0] rel;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] win_num;
    logic              below;
    logic              in_range;
    win_entry_t        sel;
    logic [2*DATA_W-1:0] xaddr;

    assign below    = (addr_i < REGION_BASE);
    assign rel      = addr_i - REGION_BASE;
    assign mask     = win_mask(size_idx_i);
    assign win_num  = rel >> win_shift(size_idx_i);
    assign in_range = !below && (win_num < DATA_W'(NUM_WIN));

    always_comb begin
        sel = '0;
        for (int n = 0; n < NUM_WIN; n++) begin
            if (win_num == DATA_W'(n)) sel = win_i[n];
        end
    end

    assign xaddr = {sel.hi, sel.lo & ~mask} + {{DATA_W{1'b0}}, rel & mask};

    always_comb begin
        res_o.hit  = xl_en_i && in_range && sel.lo[WIN_VLD_BIT];
        res_o.addr = res_o.hit ? xaddr : {{DATA_W{1'b0}}, addr_i};
    end

endmodule

// File: rtl/ob_xlate.sv
`timescale 1ns/1ps
module ob_xlate
    import ob_xlate_pkg::*;
#(
    parameter int unsigned       NUM_WIN     = 32,
    parameter logic [DATA_W-1:0] REGION_BASE = 32'h4000_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we_i,
    input  logic [REG_AW-1:0]     reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  xl_vld_i,
    input  logic [DATA_W-1:0]     xl_addr_i,
    output logic                  out_vld_o,
    output logic [2*DATA_W-1:0]   out_addr_o,
    output logic                  out_hit_o,
    output logic                  out_miss_o
);

    localparam int unsigned OUT_W = 2 * DATA_W;

    logic                     xl_en;
    logic [SZ_IDX_W-1:0]      size_idx;
    win_entry_t [NUM_WIN-1:0] win;
    xl_result_t               res;

    logic             vld_q;
    logic             hit_q;
    logic [OUT_W-1:0] addr_q;

    ob_xlate_regs #(
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .xl_en_o    (xl_en),
        .size_idx_o (size_idx),
        .win_o      (win)
    );

    ob_xlate_lookup #(
        .NUM_WIN     (NUM_WIN),
        .REGION_BASE (REGION_BASE)
    ) u_lookup (
        .xl_en_i    (xl_en),
        .size_idx_i (size_idx),
        .win_i      (win),
        .addr_i     (xl_addr_i),
        .res_o      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q <= xl_vld_i;
            if (xl_vld_i) begin
                hit_q  <= res.hit;
                addr_q <= res.addr;
            end
        end
    end

    assign out_vld_o  = vld_q;
    assign out_hit_o  = vld_q && hit_q;
    assign out_miss_o = vld_q && !hit_q;
    assign out_addr_o = addr_q;

endmodule

// File: rtl/ob_xlate_chk.sv
`timescale 1ns/1ps
module ob_xlate_chk
    import ob_xlate_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                reg_we_i,
    input logic [REG_AW-1:0]   reg_addr_i,
    input logic [DATA_W-1:0]   reg_wdata_i,
    input logic                xl_vld_i,
    input logic [DATA_W-1:0]   xl_addr_i,
    input logic                out_vld_o,
    input logic [2*DATA_W-1:0] out_addr_o,
    input logic                out_hit_o,
    input logic                out_miss_o,
    input logic                xl_en,
    input logic [SZ_IDX_W-1:0] size_idx
);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> (out_hit_o ^ out_miss_o));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !out_vld_o |-> (!out_hit_o && !out_miss_o));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        xl_vld_i |=> out_vld_o);

    p_disabled_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (xl_vld_i && !xl_en) |=> (out_miss_o && out_addr_o == {32'h0, $past(xl_addr_i)}));

    p_miss_pass_r9: assert property (@(posedge clk) disable iff (rst)
        xl_vld_i |=> (!out_miss_o || out_addr_o == {32'h0, $past(xl_addr_i)}));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_addr_i == OFS_CTRL) |=> (xl_en == $past(reg_wdata_i[CTRL_EN_BIT])));

    p_size_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_we_i && reg_addr_i == OFS_SIZE) |=> $stable(size_idx));

endmodule

bind ob_xlate ob_xlate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .xl_vld_i    (xl_vld_i),
    .xl_addr_i   (xl_addr_i),
    .out_vld_o   (out_vld_o),
    .out_addr_o  (out_addr_o),
    .out_hit_o   (out_hit_o),
    .out_miss_o  (out_miss_o),
    .xl_en       (xl_en),
    .size_idx    (size_idx)
);

// File: tb/test_ob_xlate.sv
`timescale 1ns/1ps
module test_ob_xlate;

    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xl_vld = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        out_vld;
    logic [63:0] out_addr;
    logic        out_hit;
    logic        out_miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ob_xlate #(.NUM_WIN(32), .REGION_BASE(BASE)) i_ob_xlate (
        .clk         (clk),
        .rst         (rst),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .xl_vld_i    (xl_vld),
        .xl_addr_i   (xl_addr),
        .out_vld_o   (out_vld),
        .out_addr_o  (out_addr),
        .out_hit_o   (out_hit),
        .out_miss_o  (out_miss)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    // one request, result checked on the next negedge
    task automatic xl_chk(input string req, input logic [31:0] a,
                          input logic hit, input logic [63:0] exp);
        @(negedge clk);
        xl_vld = 1'b1; xl_addr = a;
        @(negedge clk);
        xl_vld = 1'b0;
        chk(req, {61'h0, out_vld, out_hit, out_miss}, {61'h0, 1'b1, hit, !hit});
        chk(req, out_addr, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 12'h004, 32'h0);
        rd_chk("R1 size", 12'h030, 32'h0);
        rd_chk("R1 win0 lo", 12'h200, 32'h0);
        rd_chk("R1 win31 hi", 12'h2FC, 32'h0);
        xl_chk("R1 miss after reset", BASE + 32'h10, 1'b0, {32'h0, BASE + 32'h10});
    endtask

    task automatic t_regs;
        wr(12'h004, 32'hA5A5_0000);
        rd_chk("R2 ctrl readback", 12'h004, 32'hA5A5_0000);
        wr(12'h228, 32'h1357_9BDF);
        wr(12'h22C, 32'h2468_ACE0);
        rd_chk("R2 win5 lo", 12'h228, 32'h1357_9BDF);
        rd_chk("R2 win5 hi", 12'h22C, 32'h2468_ACE0);
        wr(12'h030, 32'hFFFF_FFFD);
        rd_chk("R3 size keeps 3 bits", 12'h030, 32'h0000_0005);
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk("R4 offset 0 reads zero", 12'h000, 32'h0);
        wr(12'h201, 32'hDEAD_BEEF);
        rd_chk("R4 misaligned reads zero", 12'h201, 32'h0);
        rd_chk("R4 misaligned write ignored", 12'h200, 32'h0);
        wr(12'h300, 32'hCAFE_F00D);
        rd_chk("R4 past last window reads zero", 12'h300, 32'h0);
        rd_chk("R4 past last window write ignored", 12'h2FC, 32'h0);
        rd_chk("R4 ctrl untouched", 12'h004, 32'hA5A5_0000);
        wr(12'h228, 32'h0);
        wr(12'h22C, 32'h0);
    endtask

    task automatic setup_windows;
        wr(12'h030, 32'h3);
        wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0012);
        wr(12'h208, 32'h1230_0001); wr(12'h20C, 32'h0000_ABCD);
        wr(12'h210, 32'h7770_0000); wr(12'h214, 32'h0000_0005);
        wr(12'h2F8, 32'hC000_0001); wr(12'h2FC, 32'h0000_0001);
        wr(12'h004, 32'h0000_0002);
    endtask

    task automatic t_translate;
        xl_chk("R6 win0 8MB", BASE + 32'h0012_3456, 1'b1, 64'h0000_0012_8012_3456);
        xl_chk("R5 win1 8MB", BASE + 32'h0080_0010, 1'b1, 64'h0000_ABCD_1200_0010);
        xl_chk("R6 last byte of win31", BASE + 32'h0FFF_FFFF, 1'b1, 64'h0000_0001_C07F_FFFF);
    endtask

    task automatic t_bounds;
        xl_chk("R9 first byte past window 31", BASE + 32'h1000_0000, 1'b0, {32'h0, BASE + 32'h1000_0000});
        xl_chk("R9 one below base", BASE - 32'h1, 1'b0, {32'h0, BASE - 32'h1});
    endtask

    task automatic t_invalid;
        xl_chk("R8 invalid window 2", BASE + 32'h0100_0004, 1'b0, {32'h0, BASE + 32'h0100_0004});
    endtask

    task automatic t_sizes;
        wr(12'h030, 32'h0);
        xl_chk("R5 1MB win1", BASE + 32'h0010_0020, 1'b1, 64'h0000_ABCD_1230_0020);
        xl_chk("R9 1MB index 32", BASE + 32'h0200_0000, 1'b0, {32'h0, BASE + 32'h0200_0000});
        wr(12'h030, 32'h7);
        xl_chk("R5 128MB win1", BASE + 32'h0900_0000, 1'b1, 64'h0000_ABCD_1100_0000);
        wr(12'h030, 32'h3);
    endtask

    task automatic t_global;
        wr(12'h004, 32'hFFFF_FFFD);
        xl_chk("R7 disabled pass", BASE + 32'h0012_3456, 1'b0, {32'h0, BASE + 32'h0012_3456});
        rd_chk("R2 ctrl other bits kept", 12'h004, 32'hFFFF_FFFD);
        wr(12'h004, 32'h0000_0002);
        xl_chk("R7 re-enabled", BASE + 32'h0012_3456, 1'b1, 64'h0000_0012_8012_3456);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h200; reg_wdata = 32'h0;
        xl_vld = 1'b1; xl_addr = BASE + 32'h10;
        @(negedge clk);
        reg_we = 1'b0; xl_vld = 1'b0;
        chk("R11 old contents used", {63'h0, out_hit}, 64'h1);
        chk("R11 old address", out_addr, 64'h0000_0012_8000_0010);
        xl_chk("R11 new contents next cycle", BASE + 32'h10, 1'b0, {32'h0, BASE + 32'h10});
    endtask

    task automatic t_timing;
        @(negedge clk);
        xl_vld = 1'b1; xl_addr = BASE + 32'h0080_0001;
        @(negedge clk);
        xl_addr = BASE - 32'h4;
        chk("R10 first of pair", {62'h0, out_vld, out_hit}, 64'h3);
        chk("R10 first addr", out_addr, 64'h0000_ABCD_1200_0001);
        @(negedge clk);
        xl_vld = 1'b0;
        chk("R10 second of pair", {62'h0, out_vld, out_miss}, 64'h3);
        chk("R10 second addr", out_addr, {32'h0, BASE - 32'h4});
        @(negedge clk);
        chk("R10 idle outputs low", {61'h0, out_vld, out_hit, out_miss}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 no result after reset", {61'h0, out_vld, out_hit, out_miss}, 64'h0);
        t_reset();
        t_regs();
        setup_windows();
        t_translate();
        t_bounds();
        t_invalid();
        t_sizes();
        t_global();
        t_same_cycle();
        t_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule